// File: doc/BRIEF.md
# Four-Bank Striped L1 Request Arbiter

This block sits between a multi-issue load/store front end and a first-level data store that is cut into four independent, single-ported banks. Each cycle up to four requesters may present one line-level access: a line address (the byte address with its low four bits removed), a 16-bit byte mask that already encodes those low bits, a load-or-store flag and a small tag. The two lowest line-address bits (byte-address bits [5:4]) pick the bank. The remaining upper bits become the row index inside that bank.

Requests that fall into different banks are granted together. When several requests land in one bank, the lowest-numbered input wins. Every other request for the same line and of the same kind (load or store) rides along with it: their masks are ORed into a single set of byte enables. The other requests for that bank are not granted and must be held. A granted bank access is registered and presented on the bank side for one cycle or longer, together with a bit vector of contributing inputs and their tags, so returned load data can be steered back to every contributor.

Both sides are valid/ready streams. On the input side `in_ready[p]` is the grant. It is a combinational function of the current requests and bank-side state. A requester must hold its valid and payload stable until it sees ready, and must keep valid low during reset. On the bank side an access stays on the pins, unchanged, until `bk_ready` is seen high. While a bank's output register holds an access that is not accepted, no new request for that bank is granted.

Top module: `l1sb_stripe_arb`

## Requirements
- R1: After reset every `bk_valid` bit is 0 and, with no input valid, every `in_ready` bit is 0.
- R2: A request goes to bank `line[1:0]`, and the access it produces carries `bk_index` equal to `line[LINE_W-1:2]`.
- R3: Requests on different inputs that map to different banks with free output slots are all granted in the same cycle.
- R4: Among requests to one bank that differ in line address, only the lowest-numbered valid input is granted. The others stay ungranted until a later cycle, and no request is lost or granted twice.
- R5: Every request to the same bank with the same line address and the same load/store flag as the winner is granted in the same cycle. The access byte enables are the OR of their masks, and `bk_src` has a 1 at each contributor's input number.
- R6: In the tag vector of bank b, the field at bit `(b*NPORT+p)*TAG_W` holds input p's tag when `bk_src` bit p is set and zero otherwise. An idle bank shows all-zero `bk_src`.
- R7: A load and a store to the same line are never merged. The store/load flag of the lowest-numbered request decides the access kind.
- R8: While `bk_valid[b]` is 1 and `bk_ready[b]` is 0, bank b's access outputs stay unchanged and no request for bank b is granted.
- R9: A request granted in one cycle appears on the bank side at the next clock edge.
- R10: An input whose valid is 0 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NPORT | Request valid per input |
| in_ready | output | NPORT | Grant per input |
| in_line | input | NPORT*LINE_W | Line address per input, input p at bit p*LINE_W |
| in_mask | input | NPORT*16 | Byte mask per input |
| in_store | input | NPORT | 1 for store, 0 for load |
| in_tag | input | NPORT*TAG_W | Request tag per input |
| bk_ready | input | 4 | Bank accepts the presented access |
| bk_valid | output | 4 | Access presented to bank |
| bk_store | output | 4 | Access is a write |
| bk_index | output | 4*(LINE_W-2) | Row index inside each bank |
| bk_be | output | 4*16 | Merged byte enables per bank |
| bk_src | output | 4*NPORT | Contributing inputs per bank |
| bk_tags | output | 4*NPORT*TAG_W | Contributor tags per bank |

## Verification
A wrong winner or a wrong merge set shows up on `in_ready` in the same cycle as the request. It shows up on `bk_src` and `bk_be` one clock later, so every cycle is compared against an independent model of the grant rules. A slot register that drops or overwrites a stalled access changes the bank outputs on the next edge while `bk_ready` is low. A request that is dropped or granted twice shows up as a mismatch between issued and granted counts per input once the random traffic is drained.

// File: rtl/l1sb_pkg.sv
package l1sb_pkg;
  localparam int MASK_W    = 16;
  localparam int BANK_BITS = 2;
  localparam int NBANK     = 1 << BANK_BITS;
endpackage

// File: rtl/l1sb_port_decode.sv
module l1sb_port_decode
  import l1sb_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic [NPORT-1:0][BANK_BITS-1:0] sel,
  input  logic [NPORT-1:0]                valid,
  output logic [NBANK-1:0][NPORT-1:0]     cand
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign cand[b][p] = valid[p] && (sel[p] == BANK_BITS'(b));
    end
  end
endmodule

// File: rtl/l1sb_bank_pick.sv
module l1sb_bank_pick
  import l1sb_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int LINE_W = 28,
  parameter int TAG_W  = 4
) (
  input  logic [NPORT-1:0]                    cand,
  input  logic [NPORT-1:0][LINE_W-1:0]        line,
  input  logic [NPORT-1:0]                    store,
  input  logic [NPORT-1:0][MASK_W-1:0]        mask,
  input  logic [NPORT-1:0][TAG_W-1:0]         tag,
  input  logic                                slot_free,
  output logic [NPORT-1:0]                    grant,
  output logic                                acc_valid,
  output logic                                acc_store,
  output logic [LINE_W-BANK_BITS-1:0]         acc_idx,
  output logic [MASK_W-1:0]                   acc_be,
  output logic [NPORT-1:0]                    acc_src,
  output logic [NPORT-1:0][TAG_W-1:0]         acc_tags
);
  logic              found;
  logic [LINE_W-1:0] win_line;
  logic              win_store;
  logic [NPORT-1:0]  join_set;

  // lowest-numbered candidate fixes line and kind
  always_comb begin
    found     = 1'b0;
    win_line  = '0;
    win_store = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (cand[p] && !found) begin
        found     = 1'b1;
        win_line  = line[p];
        win_store = store[p];
      end
    end
  end

  // every candidate matching line and kind joins the access
  always_comb begin
    acc_be   = '0;
    acc_tags = '0;
    for (int p = 0; p < NPORT; p++) begin
      join_set[p] = cand[p] && (line[p] == win_line) && (store[p] == win_store);
      if (join_set[p]) begin
        acc_be      = acc_be | mask[p];
        acc_tags[p] = tag[p];
      end
    end
  end

  assign acc_valid = found;
  assign acc_store = win_store;
  assign acc_idx   = win_line[LINE_W-1:BANK_BITS];
  assign acc_src   = join_set;
  assign grant     = slot_free ? join_set : '0;
endmodule

// File: rtl/l1sb_bank_slot.sv
module l1sb_bank_slot
  import l1sb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int IDX_W = 26,
  parameter int TAG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic                        acc_store,
  input  logic [IDX_W-1:0]            acc_idx,
  input  logic [MASK_W-1:0]           acc_be,
  input  logic [NPORT-1:0]            acc_src,
  input  logic [NPORT-1:0][TAG_W-1:0] acc_tags,
  input  logic                        out_ready,
  output logic                        slot_free,
  output logic                        q_valid,
  output logic                        q_store,
  output logic [IDX_W-1:0]            q_idx,
  output logic [MASK_W-1:0]           q_be,
  output logic [NPORT-1:0]            q_src,
  output logic [NPORT-1:0][TAG_W-1:0] q_tags
);
  assign slot_free = !q_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_store <= 1'b0;
      q_idx   <= '0;
      q_be    <= '0;
      q_src   <= '0;
      q_tags  <= '0;
    end else if (slot_free) begin
      q_valid <= acc_valid;
      q_store <= acc_valid && acc_store;
      q_idx   <= acc_valid ? acc_idx : '0;
      q_be    <= acc_be;
      q_src   <= acc_src;
      q_tags  <= acc_tags;
    end
  end
endmodule

// File: rtl/l1sb_stripe_arb.sv
module l1sb_stripe_arb
  import l1sb_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int LINE_W = 28,
  parameter int TAG_W  = 4,
  localparam int IDX_W = LINE_W - BANK_BITS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORT-1:0]               in_valid,
  output logic [NPORT-1:0]               in_ready,
  input  logic [NPORT*LINE_W-1:0]        in_line,
  input  logic [NPORT*MASK_W-1:0]        in_mask,
  input  logic [NPORT-1:0]               in_store,
  input  logic [NPORT*TAG_W-1:0]         in_tag,
  input  logic [NBANK-1:0]               bk_ready,
  output logic [NBANK-1:0]               bk_valid,
  output logic [NBANK-1:0]               bk_store,
  output logic [NBANK*IDX_W-1:0]         bk_index,
  output logic [NBANK*MASK_W-1:0]        bk_be,
  output logic [NBANK*NPORT-1:0]         bk_src,
  output logic [NBANK*NPORT*TAG_W-1:0]   bk_tags
);
  logic [NPORT-1:0][LINE_W-1:0]             line_a;
  logic [NPORT-1:0][MASK_W-1:0]             mask_a;
  logic [NPORT-1:0][TAG_W-1:0]              tag_a;
  logic [NPORT-1:0][BANK_BITS-1:0]          in_sel;
  logic [NBANK-1:0][NPORT-1:0]              cand;
  logic [NBANK-1:0][NPORT-1:0]              grant;
  logic [NBANK-1:0]                         slot_free;
  logic [NBANK-1:0]                         a_valid, a_store;
  logic [NBANK-1:0][IDX_W-1:0]              a_idx, q_idx;
  logic [NBANK-1:0][MASK_W-1:0]             a_be, q_be;
  logic [NBANK-1:0][NPORT-1:0]              a_src, q_src;
  logic [NBANK-1:0][NPORT-1:0][TAG_W-1:0]   a_tags, q_tags;

  assign line_a = in_line;
  assign mask_a = in_mask;
  assign tag_a  = in_tag;

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    assign in_sel[p] = line_a[p][BANK_BITS-1:0];
  end

  l1sb_port_decode #(.NPORT(NPORT)) u_dec (
    .sel   (in_sel),
    .valid (in_valid),
    .cand  (cand)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    l1sb_bank_pick #(.NPORT(NPORT), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_pick (
      .cand      (cand[b]),
      .line      (line_a),
      .store     (in_store),
      .mask      (mask_a),
      .tag       (tag_a),
      .slot_free (slot_free[b]),
      .grant     (grant[b]),
      .acc_valid (a_valid[b]),
      .acc_store (a_store[b]),
      .acc_idx   (a_idx[b]),
      .acc_be    (a_be[b]),
      .acc_src   (a_src[b]),
      .acc_tags  (a_tags[b])
    );

    l1sb_bank_slot #(.NPORT(NPORT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (a_valid[b]),
      .acc_store (a_store[b]),
      .acc_idx   (a_idx[b]),
      .acc_be    (a_be[b]),
      .acc_src   (a_src[b]),
      .acc_tags  (a_tags[b]),
      .out_ready (bk_ready[b]),
      .slot_free (slot_free[b]),
      .q_valid   (bk_valid[b]),
      .q_store   (bk_store[b]),
      .q_idx     (q_idx[b]),
      .q_be      (q_be[b]),
      .q_src     (q_src[b]),
      .q_tags    (q_tags[b])
    );
  end

  always_comb begin
    in_ready = '0;
    for (int b = 0; b < NBANK; b++) in_ready = in_ready | grant[b];
  end

  assign bk_index = q_idx;
  assign bk_be    = q_be;
  assign bk_src   = q_src;
  assign bk_tags  = q_tags;
endmodule

// File: rtl/l1sb_stripe_chk.sv
module l1sb_stripe_chk
  import l1sb_pkg::*;
#(
  parameter int NPORT = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NPORT-1:0]               in_valid,
  input logic [NPORT-1:0]               in_ready,
  input logic [NPORT-1:0][BANK_BITS-1:0] in_sel,
  input logic [NBANK-1:0]               bk_ready,
  input logic [NBANK-1:0]               bk_valid,
  input logic [NBANK*MASK_W-1:0]        bk_be,
  input logic [NBANK*NPORT-1:0]         bk_src
);
  logic [NBANK-1:0][NPORT-1:0] granted_to;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      for (int p = 0; p < NPORT; p++)
        granted_to[b][p] = in_ready[p] && (in_sel[p] == BANK_BITS'(b));
  end

  a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    a_r8_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[b] && !bk_ready[b] |=> bk_valid[b]
        && $stable(bk_be[b*MASK_W +: MASK_W]) && $stable(bk_src[b*NPORT +: NPORT]));

    a_r8_no_grant_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[b] && !bk_ready[b] |-> granted_to[b] == '0);

    a_r9_grant_appears: assert property (@(posedge clk) disable iff (!rst_n)
      granted_to[b] != '0 |=> bk_valid[b] && bk_src[b*NPORT +: NPORT] == $past(granted_to[b]));

    a_r6_idle_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bk_valid[b] |-> bk_src[b*NPORT +: NPORT] == '0);
  end
endmodule

bind l1sb_stripe_arb l1sb_stripe_chk #(.NPORT(NPORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sel   (in_sel),
  .bk_ready (bk_ready),
  .bk_valid (bk_valid),
  .bk_be    (bk_be),
  .bk_src   (bk_src)
);

// File: tb/sim_l1sb_stripe_arb.sv
`timescale 1ns/1ps
module sim_l1sb_stripe_arb;
  localparam int NP = 4;
  localparam int LW = 28;
  localparam int TW = 4;
  localparam int NB = 4;
  localparam int IW = LW - 2;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]       in_valid = '0;
  logic [NP-1:0]       in_ready;
  logic [NP*LW-1:0]    in_line = '0;
  logic [NP*MW-1:0]    in_mask = '0;
  logic [NP-1:0]       in_store = '0;
  logic [NP*TW-1:0]    in_tag = '0;
  logic [NB-1:0]       bk_ready = '1;
  logic [NB-1:0]       bk_valid, bk_store;
  logic [NB*IW-1:0]    bk_index;
  logic [NB*MW-1:0]    bk_be;
  logic [NB*NP-1:0]    bk_src;
  logic [NB*NP*TW-1:0] bk_tags;

  always #2.5 clk = ~clk;

  l1sb_stripe_arb #(.NPORT(NP), .LINE_W(LW), .TAG_W(TW)) u0 (.*);

  int tests = 0;
  int fails = 0;

  // pending requests per input
  logic          pv [NP];
  logic [LW-1:0] pl [NP];
  logic [MW-1:0] pm [NP];
  logic          ps [NP];
  logic [TW-1:0] pt [NP];
  int gen_cnt [NP];
  int gnt_cnt [NP];

  // expected bank-side registers
  logic          mv [NB];
  logic          mst [NB];
  logic [IW-1:0] mi [NB];
  logic [MW-1:0] mb [NB];
  logic [NP-1:0] msrc [NB];
  logic [NP*TW-1:0] mtg [NB];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive, predict grants, clock, compare bank side
  task automatic step(output logic [NP-1:0] eg);
    logic          nv [NB];
    logic          nst [NB];
    logic [IW-1:0] ni [NB];
    logic [MW-1:0] nbe [NB];
    logic [NP-1:0] nsrc [NB];
    logic [NP*TW-1:0] ntg [NB];
    logic free [NB];
    for (int p = 0; p < NP; p++) begin
      in_valid[p] = pv[p];
      in_line[p*LW +: LW] = pl[p];
      in_mask[p*MW +: MW] = pm[p];
      in_store[p] = ps[p];
      in_tag[p*TW +: TW] = pt[p];
    end
    #1;
    eg = '0;
    for (int b = 0; b < NB; b++) begin
      bit found = 0;
      logic [LW-1:0] wl = '0;
      logic ws = 0;
      free[b] = !mv[b] || bk_ready[b];
      nv[b] = 0; nst[b] = 0; ni[b] = '0; nbe[b] = '0; nsrc[b] = '0; ntg[b] = '0;
      for (int p = 0; p < NP; p++)
        if (pv[p] && pl[p][1:0] == b[1:0] && !found) begin
          found = 1; wl = pl[p]; ws = ps[p];
        end
      if (found) begin
        nv[b] = 1; nst[b] = ws; ni[b] = wl[LW-1:2];
        for (int p = 0; p < NP; p++)
          if (pv[p] && pl[p] == wl && ps[p] == ws) begin
            nbe[b] = nbe[b] | pm[p];
            nsrc[b][p] = 1'b1;
            ntg[b][p*TW +: TW] = pt[p];
            if (free[b]) eg[p] = 1'b1;
          end
      end
    end
    chk(in_ready == eg, "R4/R5/R7/R8/R10 grant vector", 64'(in_ready), 64'(eg));
    @(posedge clk);
    for (int b = 0; b < NB; b++)
      if (free[b]) begin
        mv[b] = nv[b]; mst[b] = nst[b]; mi[b] = ni[b];
        mb[b] = nbe[b]; msrc[b] = nsrc[b]; mtg[b] = ntg[b];
      end
    for (int p = 0; p < NP; p++)
      if (eg[p]) begin
        pv[p] = 1'b0;
        gnt_cnt[p]++;
      end
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      chk(bk_valid[b] == mv[b], "R9 bank valid", 64'(bk_valid[b]), 64'(mv[b]));
      chk(bk_src[b*NP +: NP] == msrc[b], "R5 contributors", 64'(bk_src[b*NP +: NP]), 64'(msrc[b]));
      chk(bk_tags[b*NP*TW +: NP*TW] == mtg[b], "R6 tags", 64'(bk_tags[b*NP*TW +: NP*TW]), 64'(mtg[b]));
      if (mv[b]) begin
        chk(bk_be[b*MW +: MW] == mb[b], "R5 byte enables", 64'(bk_be[b*MW +: MW]), 64'(mb[b]));
        chk(bk_index[b*IW +: IW] == mi[b], "R2 index", 64'(bk_index[b*IW +: IW]), 64'(mi[b]));
        chk(bk_store[b] == mst[b], "R7 kind", 64'(bk_store[b]), 64'(mst[b]));
      end
    end
  endtask

  task automatic put(input int p, input logic [LW-1:0] l, input logic [MW-1:0] m, input logic s, input logic [TW-1:0] t);
    pv[p] = 1'b1; pl[p] = l; pm[p] = m; ps[p] = s; pt[p] = t;
    gen_cnt[p]++;
  endtask

  initial begin
    #(5.0 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [NP-1:0] g;
    bit st_epoch;
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) begin
      pv[p] = 0; pl[p] = '0; pm[p] = '0; ps[p] = 0; pt[p] = '0;
      gen_cnt[p] = 0; gnt_cnt[p] = 0;
    end
    for (int b = 0; b < NB; b++) begin
      mv[b] = 0; mst[b] = 0; mi[b] = '0; mb[b] = '0; msrc[b] = '0; mtg[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bk_valid == '0, "R1 bank idle", 64'(bk_valid), 64'h0);
    chk(in_ready == '0, "R1 no grant", 64'(in_ready), 64'h0);

    // R3: one request per bank
    for (int p = 0; p < NP; p++) put(p, LW'(p + 20), MW'(16'h1 << p), 1'b0, TW'(p + 1));
    step(g);
    chk(g == 4'hF && in_ready == 4'hF, "R3 all banks at once", 64'(in_ready), 64'hF);
    chk(bk_index[3*IW +: IW] == IW'(23 >> 2), "R2 bank 3 index", 64'(bk_index[3*IW +: IW]), 64'(23 >> 2));

    // R4: four different lines in bank 0
    for (int p = 0; p < NP; p++) put(p, LW'(4 * (p + 1)), 16'h00FF, 1'b0, TW'(p));
    step(g); chk(g == 4'h1, "R4 lowest first", 64'(g), 64'h1);
    step(g); chk(g == 4'h2, "R4 next port", 64'(g), 64'h2);
    step(g); chk(g == 4'h4, "R4 third port", 64'(g), 64'h4);
    step(g); chk(g == 4'h8, "R4 last port", 64'(g), 64'h8);

    // R5/R6: same line stores merged
    put(0, LW'(5), 16'h000F, 1'b1, 4'hA);
    put(1, LW'(5), 16'h00F0, 1'b1, 4'hB);
    put(2, LW'(5), 16'h0F00, 1'b1, 4'hC);
    put(3, LW'(5), 16'h8000, 1'b1, 4'hD);
    step(g);
    chk(g == 4'hF, "R5 merged grant", 64'(g), 64'hF);
    chk(bk_be[1*MW +: MW] == 16'h8FFF, "R5 ORed mask", 64'(bk_be[1*MW +: MW]), 64'h8FFF);
    chk(bk_tags[1*NP*TW +: NP*TW] == 16'hDCBA, "R6 tag slots", 64'(bk_tags[1*NP*TW +: NP*TW]), 64'hDCBA);

    // R7: load/store mix on one line
    put(0, LW'(6), 16'h0001, 1'b0, 4'h1);
    put(1, LW'(6), 16'h0002, 1'b1, 4'h2);
    put(2, LW'(6), 16'h0004, 1'b0, 4'h3);
    step(g); chk(g == 4'h5, "R7 loads first", 64'(g), 64'h5);
    chk(bk_store[2] == 1'b0, "R7 load access", 64'(bk_store[2]), 64'h0);
    step(g); chk(g == 4'h2, "R7 store later", 64'(g), 64'h2);

    // R8: stalled bank 2
    step(g);
    bk_ready = 4'b1011;
    put(0, LW'(10), 16'h0003, 1'b0, 4'h4);
    step(g); chk(g == 4'h1, "R8 empty slot fills", 64'(g), 64'h1);
    put(1, LW'(14), 16'h0030, 1'b0, 4'h5);
    step(g); chk(g == 4'h0, "R8 stalled no grant", 64'(g), 64'h0);
    step(g); chk(bk_be[2*MW +: MW] == 16'h0003, "R8 held access", 64'(bk_be[2*MW +: MW]), 64'h3);
    bk_ready = 4'hF;
    step(g); chk(g == 4'h2, "R8 released", 64'(g), 64'h2);

    // R10: idle
    step(g); chk(g == 4'h0 && in_ready == 4'h0, "R10 idle", 64'(in_ready), 64'h0);

    // random traffic
    st_epoch = 0;
    for (int c = 0; c < 4000; c++) begin
      if (c % 50 == 0) st_epoch = ~st_epoch;
      for (int p = 0; p < NP; p++)
        if (!pv[p] && ($urandom % 100) < 60)
          put(p, LW'((($urandom % 3) << 2) | ($urandom % 4)), MW'($urandom),
              (($urandom % 100) < 5) ? ~st_epoch : st_epoch, TW'($urandom));
      for (int b = 0; b < NB; b++) bk_ready[b] = (($urandom % 100) < 80);
      step(g);
    end
    bk_ready = 4'hF;
    for (int c = 0; c < 20; c++) step(g);
    for (int p = 0; p < NP; p++)
      chk(gen_cnt[p] == gnt_cnt[p] && !pv[p], "R4 each request granted once",
          64'(gnt_cnt[p]), 64'(gen_cnt[p]));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule